// File: doc/BRIEF.md
# Full-Bridge Antiphase Drive Generator

This block produces the gate-drive timing for a full-bridge RF power stage. Two drive legs fire in opposite halves of a fixed 104-cycle period (461 kHz from a 48 MHz clock). Each drive pulse is followed at once by a short transformer-reset pulse on its own output. The pulse width is taken from an 8-bit mode byte. The byte is captured on an activation strobe, and only a small set of codes selects bridge operation. Any other code leaves the bridge idle.

Three control pins gate the outputs: an RF enable, an active-high permit line and an active-low bridge enable. If any of them withdraws permission during a pulse, both drives drop on the next clock edge. A reset pulse that is owed still runs to its end, and drive does not resume until the next period boundary. All pins are plain control levels. There is no data stream, so the block has no handshake.

Top module: `bridge_driver`

## Requirements
- R1: While `rst` is high and afterwards, all four outputs are low until a bridge-driving code has been captured with all gates open. The captured code resets to 00h, which does not drive.
- R2: With gates open and a driving code held, leg A rises exactly once every 104 clock cycles.
- R3: Leg B rises 52 cycles after each rise of leg A, and the two drive outputs are never high in the same cycle.
- R4: Code 39h (cut) gives pulses 48 cycles wide on both legs.
- R5: The nine blend codes 37h, 35h, 33h, 31h, 29h, 27h, 25h, 23h and 21h are levels 1 to 9. Level k gives a width of 48 - 3k cycles.
- R6: Code 6Fh (bipolar) gives 40-cycle pulses, and code 43h (pinpoint) gives 30-cycle pulses.
- R7: Every other code value gives no drive pulse on either leg.
- R8: `mode_code` is captured only on a clock edge where `act_req` is high. Changing it without the strobe does not change the pulse width.
- R9: Drive requires `rf_en` = 1, `rf_permit` = 1 and `br_en_n` = 0. When any of these fails, both drives are low from the next clock edge.
- R10: Each falling edge of a drive starts that leg's reset output in the first cycle the drive is low. The reset output stays high for exactly 10 cycles and is never high together with its own drive.
- R11: After a forced drop, the reset pulse still lasts 10 cycles. With gates reopened at once, the next leg-A rise comes 104 cycles after the interrupted rise, and leg B stays low in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| act_req | input | 1 | Activation strobe; captures `mode_code` |
| mode_code | input | 8 | Mode byte selecting bridge use and width |
| rf_en | input | 1 | RF enable, high to allow drive |
| rf_permit | input | 1 | Permit line; low inhibits drive |
| br_en_n | input | 1 | Bridge enable, active low |
| drv_a | output | 1 | Drive leg A, first half of the period |
| drv_b | output | 1 | Drive leg B, second half of the period |
| xrst_a | output | 1 | Reset pulse after each leg-A pulse |
| xrst_b | output | 1 | Reset pulse after each leg-B pulse |

## Verification
A gate withdrawal and the start of a reset pulse fall in the same cycle. The forced drop of a drive is itself the falling edge that launches the reset pulse. The bench closes `rf_en` five cycles into a leg-A pulse and reopens it one cycle later. In the first cycle after the edge it expects the drive low and the reset high. It then counts exactly ten reset cycles and expects the restart 104 cycles after the cut-short rise, with leg B held low through the skipped half.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;

  // Pulse width in clock cycles for a captured mode byte; 0 means no bridge drive.
  function automatic int unsigned mode_width(input logic [7:0] code,
                                             input int unsigned w_cut,
                                             input int unsigned w_step,
                                             input int unsigned w_bip,
                                             input int unsigned w_ppt);
    case (code)
      8'h39: return w_cut;
      8'h37: return w_cut - 1 * w_step;
      8'h35: return w_cut - 2 * w_step;
      8'h33: return w_cut - 3 * w_step;
      8'h31: return w_cut - 4 * w_step;
      8'h29: return w_cut - 5 * w_step;
      8'h27: return w_cut - 6 * w_step;
      8'h25: return w_cut - 7 * w_step;
      8'h23: return w_cut - 8 * w_step;
      8'h21: return w_cut - 9 * w_step;
      8'h6F: return w_bip;
      8'h43: return w_ppt;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/bdrv_mode.sv
module bdrv_mode #(
  parameter int HALF   = 52,
  parameter int W_CUT  = 48,
  parameter int W_STEP = 3,
  parameter int W_BIP  = 40,
  parameter int W_PPT  = 30,
  parameter int CW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_req,
  input  logic [7:0]    mode_code,
  output logic [CW-1:0] width
);
  import bdrv_pkg::*;

  logic [7:0]  mode_q;
  int unsigned raw_w;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 8'h00;
    else if (act_req) mode_q <= mode_code;
  end

  always_comb begin
    raw_w = mode_width(mode_q, W_CUT, W_STEP, W_BIP, W_PPT);
    if (raw_w > HALF) raw_w = HALF;
    width = CW'(raw_w);
  end
endmodule

// File: rtl/bdrv_phase.sv
module bdrv_phase #(
  parameter int PERIOD = 104,
  parameter int CW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  output logic [CW-1:0] cnt,
  output logic          run
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (!gate)             run <= 1'b0;
      else if (cnt == LAST)  run <= 1'b1;
    end
  end
endmodule

// File: rtl/bdrv_leg.sv
module bdrv_leg #(
  parameter int OFFSET  = 0,
  parameter int HALF    = 52,
  parameter int RST_LEN = 10,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          run,
  input  logic          gate,
  input  logic [CW-1:0] width,
  output logic          drv,
  output logic          rpulse
);
  localparam int RW = $clog2(RST_LEN + 1);

  logic [CW-1:0] pos;
  logic          drv_d;
  logic [RW-1:0] rcnt;

  always_comb begin
    pos   = cnt - CW'(OFFSET);
    drv_d = gate && run && (pos < CW'(HALF)) && (pos < width);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv  <= 1'b0;
      rcnt <= '0;
    end else begin
      drv <= drv_d;
      if (drv && !drv_d)   rcnt <= RW'(RST_LEN);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end
  end

  assign rpulse = (rcnt != '0);
endmodule

// File: rtl/bridge_driver.sv
module bridge_driver #(
  parameter int PERIOD  = 104,
  parameter int RST_LEN = 10,
  parameter int W_CUT   = 48,
  parameter int W_STEP  = 3,
  parameter int W_BIP   = 40,
  parameter int W_PPT   = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       act_req,
  input  logic [7:0] mode_code,
  input  logic       rf_en,
  input  logic       rf_permit,
  input  logic       br_en_n,
  output logic       drv_a,
  output logic       drv_b,
  output logic       xrst_a,
  output logic       xrst_b
);
  localparam int HALF = PERIOD / 2;
  localparam int CW   = $clog2(PERIOD + 1);

  logic [CW-1:0] width;
  logic [CW-1:0] cnt;
  logic          run;
  logic          gate;
  logic [1:0]    drv_v;
  logic [1:0]    rp_v;

  bdrv_mode #(.HALF(HALF), .W_CUT(W_CUT), .W_STEP(W_STEP), .W_BIP(W_BIP),
              .W_PPT(W_PPT), .CW(CW)) u_mode (
    .clk(clk), .rst(rst), .act_req(act_req), .mode_code(mode_code), .width(width)
  );

  assign gate = rf_en && rf_permit && !br_en_n && (width != '0);

  bdrv_phase #(.PERIOD(PERIOD), .CW(CW)) u_phase (
    .clk(clk), .rst(rst), .gate(gate), .cnt(cnt), .run(run)
  );

  for (genvar i = 0; i < 2; i++) begin : g_leg
    bdrv_leg #(.OFFSET(i * HALF), .HALF(HALF), .RST_LEN(RST_LEN), .CW(CW)) u_leg (
      .clk(clk), .rst(rst), .cnt(cnt), .run(run), .gate(gate), .width(width),
      .drv(drv_v[i]), .rpulse(rp_v[i])
    );
  end

  assign drv_a  = drv_v[0];
  assign drv_b  = drv_v[1];
  assign xrst_a = rp_v[0];
  assign xrst_b = rp_v[1];
endmodule

// File: rtl/bridge_driver_checker.sv
module bridge_driver_checker (
  input logic clk,
  input logic rst,
  input logic rf_en,
  input logic rf_permit,
  input logic br_en_n,
  input logic drv_a,
  input logic drv_b,
  input logic xrst_a,
  input logic xrst_b
);
  assert_antiphase_R3: assert property (@(posedge clk) disable iff (rst)
    !(drv_a && drv_b));

  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    !(rf_en && rf_permit && !br_en_n) |=> (!drv_a && !drv_b));

  assert_rst_start_a_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_a) |-> xrst_a);

  assert_rst_start_b_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_b) |-> xrst_b);

  assert_rst_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(xrst_a && drv_a) && !(xrst_b && drv_b));

  assert_rst_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(xrst_a) |-> $fell(drv_a));
endmodule

bind bridge_driver bridge_driver_checker u_chk (
  .clk(clk), .rst(rst), .rf_en(rf_en), .rf_permit(rf_permit), .br_en_n(br_en_n),
  .drv_a(drv_a), .drv_b(drv_b), .xrst_a(xrst_a), .xrst_b(xrst_b)
);

// File: tb/test_bridge_driver.sv
module test_bridge_driver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       act_req = 1'b0;
  logic [7:0] mode_code = 8'h00;
  logic       rf_en = 1'b0;
  logic       rf_permit = 1'b0;
  logic       br_en_n = 1'b1;
  wire        drv_a, drv_b, xrst_a, xrst_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // measurement results of the last observation window
  int a_w, b_w, a_per, ab_gap, ra_len, rb_len, a_rises;
  bit hi_seen, both_hi, rst_start_ok, rst_overlap;

  always #4 clk = ~clk;

  bridge_driver i_bridge_driver (
    .clk(clk), .rst(rst), .act_req(act_req), .mode_code(mode_code),
    .rf_en(rf_en), .rf_permit(rf_permit), .br_en_n(br_en_n),
    .drv_a(drv_a), .drv_b(drv_b), .xrst_a(xrst_a), .xrst_b(xrst_b)
  );

  function automatic int exp_width(input logic [7:0] c);
    case (c)
      8'h39: return 48;
      8'h37: return 45; 8'h35: return 42; 8'h33: return 39;
      8'h31: return 36; 8'h29: return 33; 8'h27: return 30;
      8'h25: return 27; 8'h23: return 24; 8'h21: return 21;
      8'h6F: return 40;
      8'h43: return 30;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic activate(input logic [7:0] c);
    mode_code = c;
    act_req   = 1'b1;
    @(negedge clk);
    act_req   = 1'b0;
  endtask

  task automatic observe(input int n);
    bit pa, pb, pra, prb;
    int ta, tb, rca, rcb;
    a_w = -1; b_w = -1; a_per = -1; ab_gap = -1; ra_len = -1; rb_len = -1;
    a_rises = 0; hi_seen = 0; both_hi = 0; rst_start_ok = 1; rst_overlap = 0;
    ta = -1; tb = -1; rca = -1000; rcb = -1000;
    pa = drv_a; pb = drv_b; pra = xrst_a; prb = xrst_b;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (drv_a && !pa) begin
        if (ta >= 0) a_per = i - ta;
        ta = i; a_rises++;
      end
      if (!drv_a && pa && ta >= 0) a_w = i - ta;
      if (drv_b && !pb) begin
        tb = i;
        if (ta >= 0) ab_gap = i - ta;
      end
      if (!drv_b && pb && tb >= 0) b_w = i - tb;
      if ((!drv_a && pa && !xrst_a) || (!drv_b && pb && !xrst_b)) rst_start_ok = 0;
      if ((xrst_a && drv_a) || (xrst_b && drv_b)) rst_overlap = 1;
      if (xrst_a && !pra) rca = 1; else if (xrst_a) rca++;
      if (!xrst_a && pra && rca > 0) ra_len = rca;
      if (xrst_b && !prb) rcb = 1; else if (xrst_b) rcb++;
      if (!xrst_b && prb && rcb > 0) rb_len = rcb;
      if (drv_a || drv_b) hi_seen = 1;
      if (drv_a && drv_b) both_hi = 1;
      pa = drv_a; pb = drv_b; pra = xrst_a; prb = xrst_b;
    end
  endtask

  task automatic check_mode(input logic [7:0] c, input string req);
    int ew;
    ew = exp_width(c);
    observe(330);
    if (ew == 0) begin
      chk(!hi_seen, req, hi_seen, 0);
    end else begin
      chk(a_w == ew, req, a_w, ew);
      chk(b_w == ew, req, b_w, ew);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [12] = '{8'h39, 8'h37, 8'h35, 8'h33, 8'h31, 8'h29,
                               8'h27, 8'h25, 8'h23, 8'h21, 8'h6F, 8'h43};
    int e, cnt;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!drv_a && !drv_b && !xrst_a && !xrst_b, "R1 reset", drv_a | drv_b | xrst_a | xrst_b, 0);
    rst = 1'b0;
    rf_en = 1'b1; rf_permit = 1'b1; br_en_n = 1'b0;
    observe(300);
    chk(!hi_seen && ra_len < 0, "R1 no code captured", hi_seen, 0);

    // R4, R2, R3, R10: cut
    activate(8'h39);
    observe(330);
    chk(a_w == 48, "R4 cut width", a_w, 48);
    chk(a_per == 104, "R2 period", a_per, 104);
    chk(ab_gap == 52, "R3 leg B offset", ab_gap, 52);
    chk(!both_hi, "R3 no overlap", both_hi, 0);
    chk(ra_len == 10, "R10 reset A length", ra_len, 10);
    chk(rb_len == 10, "R10 reset B length", rb_len, 10);
    chk(rst_start_ok && !rst_overlap, "R10 reset start", rst_start_ok, 1);

    // R8: code change without strobe
    mode_code = 8'h6F;
    observe(330);
    chk(a_w == 48, "R8 no strobe keeps width", a_w, 48);
    activate(8'h6F);
    check_mode(8'h6F, "R6 bipolar");
    activate(8'h43);
    check_mode(8'h43, "R6 pinpoint");

    // R5: every blend level
    for (int k = 1; k < 10; k++) begin
      activate(codes[k]);
      check_mode(codes[k], "R5 blend level");
    end

    // R7: codes that do not drive
    activate(8'h82);
    check_mode(8'h82, "R7 non-bridge code");
    activate(8'h38);
    check_mode(8'h38, "R7 near-cut code");

    // R9 plus random codes: random gate patterns
    for (int n = 0; n < 16; n++) begin
      logic [7:0] c;
      bit exp_on;
      if ($urandom_range(0, 3) == 0) c = 8'($urandom);
      else c = codes[$urandom_range(0, 11)];
      rf_en = 1'($urandom); rf_permit = 1'($urandom); br_en_n = 1'($urandom);
      activate(c);
      exp_on = rf_en && rf_permit && !br_en_n && (exp_width(c) != 0);
      observe(330);
      chk(hi_seen == exp_on, "R9 gate pattern", hi_seen, exp_on);
      if (exp_on) chk(a_w == exp_width(c), "R9 width when open", a_w, exp_width(c));
      chk(!both_hi && rst_start_ok, "R3 random antiphase", both_hi, 0);
    end

    // R11: forced drop mid-pulse, same cycle as reset launch
    rf_en = 1'b1; rf_permit = 1'b1; br_en_n = 1'b0;
    activate(8'h39);
    observe(220);
    while (drv_a) @(negedge clk);
    while (!drv_a) @(negedge clk);
    e = 0;
    repeat (5) begin @(negedge clk); e++; end
    rf_en = 1'b0;
    @(negedge clk); e++;
    chk(!drv_a && !drv_b, "R9 drop next edge", drv_a, 0);
    chk(xrst_a, "R11 reset launched", xrst_a, 1);
    rf_en = 1'b1;
    cnt = 0;
    while (xrst_a && cnt < 50) begin
      cnt++;
      if (drv_b) hi_seen = 1;
      @(negedge clk); e++;
    end
    chk(cnt == 10, "R11 reset completes", cnt, 10);
    hi_seen = 0;
    while (!drv_a && e < 400) begin
      if (drv_b) hi_seen = 1;
      @(negedge clk); e++;
    end
    chk(e == 104, "R11 restart at boundary", e, 104);
    chk(!hi_seen, "R11 leg B idle", hi_seen, 0);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!drv_a && !drv_b && !xrst_a && !xrst_b, "R1 reset mid-run", drv_a | xrst_a, 0);
    rst = 1'b0;
    observe(300);
    chk(!hi_seen, "R1 code cleared by reset", hi_seen, 0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule